// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for Ethernet PHYs. It generates the management clock from the system clock with a programmable divider and shifts complete Clause 22 read and write frames over a single bidirectional data line, split into output, output enable and input pins. Software controls it through a two-register port: a control/status word that holds the divider, the engine enable, the preamble switch, the fault detector and the idle flag, and a user-access word that holds the operation, the PHY and register addresses, the data and a GO bit.

Software writes the user-access word with GO set. When the engine is enabled, the next falling management-clock edge starts the frame. Outputs change only on falling edges, and the input is sampled on rising edges. When the frame ends, GO clears itself and, for a read, the received halfword appears in the data field. If the engine is disabled during a frame, that frame still runs to completion. If the fault detector sees the line disagree with what the block drives, the frame is aborted and a sticky fault flag is raised.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word (select 0) reads 0x810000FF: idle bit 31 = 1, enable bit 30 = 0, channel field bits 28:24 = 1, preamble-off bit 20 = 0, fault bit 19 = 0, detect-enable bit 18 = 0, divider bits 15:0 = 255, all other bits 0. The user word (select 1) reads 0.
- R2: For a nonzero divider D, the management clock has a period of exactly D+1 system clocks.
- R3: With a divider of 0 the management clock stays low and a pending frame makes no progress. A nonzero divider lets it proceed.
- R4: A frame is sent MSB first, one bit per management-clock period, with outputs changing only while the clock is low. The bits are 32 ones, start 01, opcode (write 01, read 10), 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. A write drives every bit, with turnaround 10 and the data from user word bits 15:0. The user word holds GO in bit 31, write-select in bit 30, the register address in bits 25:21 and the PHY address in bits 20:16.
- R5: On a read the output enable is low for the two turnaround bits and the 16 data bits. The data bits are sampled on rising edges, and at completion they appear in user word bits 15:0 while GO (bit 31) returns to 0.
- R6: With preamble-off set, the frame omits the 32 ones and is 32 bits long.
- R7: While enable is 0, a set GO bit starts no frame: no bit is driven and GO stays 1 until the engine is enabled.
- R8: Clearing enable during a frame lets that frame complete with all its bits, after which no new frame starts.
- R9: The idle bit reads 0 while a frame is being shifted and 1 otherwise.
- R10: With detect-enable set, a mismatch between the input pin and the driven value during a driven bit sets the fault bit, aborts the frame (output enable low, idle 1) and clears GO. A later frame runs normally.
- R11: Writing 1 to fault bit 19 clears it. Writing 0 leaves it unchanged.
- R12: With detect-enable clear, line mismatches are ignored and the frame completes with the fault bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 control, 1 user access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The frame engine is swept over both operations, both preamble settings and address and data patterns that include all-zero, all-one, alternating and end-bit-only words. The all-zero and all-one words expose stuck or shifted data bits, while the alternating and end-bit patterns separate MSB-first from LSB-first order and off-by-one framing. The clock divider is checked with several small values so that period errors of one cycle show up. The control paths are tested in separate scenarios: a stopped clock, GO while disabled, disable in mid-frame, an injected line fault with detection on and off, and the write-one-to-clear fault flag. Each scenario observes the pins or read-back values that would reveal a wrongly started or wrongly aborted frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 255,
  parameter int TOP_CH  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int LAST = 63;
  localparam int TA   = 46;
  localparam int DAT  = 48;

  logic [DIV_W-1:0] clkdiv, cnt, cnt_next;
  logic [DIV_W:0]   half;
  logic             en, pre_off, fen, fault;
  logic             busy, go, wr_op;
  logic [4:0]       phy, ra;
  logic [15:0]      data, rx;
  logic [5:0]       bitn;
  logic             run, fall_ev, rise_ev, mism;
  logic [63:0]      frame;

  assign run      = clkdiv != '0;
  assign fall_ev  = run && (cnt >= clkdiv);
  assign cnt_next = !run ? '0 : (fall_ev ? '0 : cnt + 1'b1);
  assign half     = ({1'b0, clkdiv} + 1'b1) >> 1;
  assign rise_ev  = run && !mdc && ({1'b0, cnt_next} >= half);

  assign frame = {32'hFFFF_FFFF, 2'b01, (wr_op ? 2'b01 : 2'b10), phy, ra,
                  (wr_op ? 2'b10 : 2'b00), (wr_op ? data : 16'h0000)};

  assign mdio_o  = busy ? frame[6'd63 - bitn] : 1'b1;
  assign mdio_oe = busy && (wr_op || bitn < 6'(TA));
  assign mism    = fen && mdio_oe && rise_ev && (mdio_i != mdio_o);

  assign reg_rdata = reg_sel
    ? {go, wr_op, 4'b0, ra, phy, data}
    : {!busy, en, 1'b0, 5'(TOP_CH), 3'b0, pre_off, fault, fen, 2'b0, 16'(clkdiv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkdiv  <= DIV_W'(DIV_RST);
      cnt     <= '0;
      mdc     <= 1'b0;
      en      <= 1'b0;
      pre_off <= 1'b0;
      fen     <= 1'b0;
      fault   <= 1'b0;
      busy    <= 1'b0;
      go      <= 1'b0;
      wr_op   <= 1'b0;
      phy     <= '0;
      ra      <= '0;
      data    <= '0;
      rx      <= '0;
      bitn    <= '0;
    end else begin
      cnt <= cnt_next;
      mdc <= run && ({1'b0, cnt_next} >= half);

      if (reg_wr && !reg_sel) begin
        en      <= reg_wdata[30];
        pre_off <= reg_wdata[20];
        fen     <= reg_wdata[18];
        clkdiv  <= reg_wdata[DIV_W-1:0];
        if (reg_wdata[19]) fault <= 1'b0;
      end

      if (reg_wr && reg_sel && !go) begin
        go    <= reg_wdata[31];
        wr_op <= reg_wdata[30];
        ra    <= reg_wdata[25:21];
        phy   <= reg_wdata[20:16];
        data  <= reg_wdata[15:0];
      end

      if (busy && rise_ev && !wr_op && bitn >= 6'(DAT))
        rx <= {rx[14:0], mdio_i};

      if (fall_ev) begin
        if (busy) begin
          if (bitn == 6'(LAST)) begin
            busy <= 1'b0;
            go   <= 1'b0;
            if (!wr_op) data <= rx;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end else if (go && en) begin
          busy <= 1'b1;
          bitn <= pre_off ? 6'd32 : 6'd0;
        end
      end

      if (mism) begin
        fault <= 1'b1;
        busy  <= 1'b0;
        go    <= 1'b0;
      end
    end
  end
endmodule

module mdio_master_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             wr_op,
  input logic [5:0]       bitn,
  input logic [DIV_W-1:0] clkdiv,
  input logic             fault
);
  // R4
  hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R3
  stopped_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkdiv == '0) |=> (!mdc && $stable(bitn)));

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_op && bitn >= 6'd46) |-> !mdio_oe);

  // R9
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R10
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!busy && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;

  logic        cap_on = 1'b0;
  logic        started = 1'b0;
  int          idx = 0;
  int          off = 0;
  logic [15:0] phy_rd = '0;
  logic        inject = 1'b0;
  logic        cap_o [0:63];
  logic        cap_oe[0:63];
  logic        mdc_prev = 1'b0;
  int          cyc = 0;
  int          prev_rise = 0;
  int          last_rise = 0;
  logic        phy_bit;

  always #5 clk = ~clk;

  mdio_master u_mdio_master (.*);

  always_comb begin
    int p;
    p = off + idx;
    if (p == 46)      phy_bit = 1'b1;
    else if (p == 47) phy_bit = 1'b0;
    else if (p >= 48 && p <= 63) phy_bit = phy_rd[63 - p];
    else              phy_bit = 1'b1;
  end

  assign mdio_i = inject ? ~mdio_o : (mdio_oe ? mdio_o : phy_bit);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !mdc_prev) begin
      prev_rise = last_rise;
      last_rise = cyc;
      if (cap_on && (started || mdio_oe) && idx < 64) begin
        started = 1'b1;
        cap_o[idx]  = mdio_o;
        cap_oe[idx] = mdio_oe;
        idx = idx + 1;
      end
    end
    mdc_prev = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] cw(input bit e, input bit pre, input bit fe, input bit f1, input logic [15:0] dv);
    return {1'b0, e, 9'b0, pre, f1, fe, 2'b0, dv};
  endfunction

  function automatic logic [31:0] uw(input bit w, input logic [4:0] ph, input logic [4:0] r, input logic [15:0] d);
    return {1'b1, w, 4'b0, r, ph, d};
  endfunction

  task automatic begin_cap(input bit pre, input logic [15:0] rv);
    off = pre ? 32 : 0; phy_rd = rv; idx = 0; started = 1'b0; cap_on = 1'b1;
  endtask

  task automatic end_check(input bit w, input logic [4:0] ph, input logic [4:0] r,
                           input logic [15:0] d, input logic [15:0] rv, input string req);
    logic [31:0] v;
    logic [63:0] ex;
    int bad;
    bit done;
    done = 0;
    for (int n = 0; n < 3000 && !done; n++) begin
      @(negedge clk);
      rd(1'b1, v);
      if (!v[31]) done = 1;
    end
    cap_on = 1'b0;
    chk(done, {req, " GO clears"}, {31'b0, v[31]}, 32'h0);
    chk(idx == 64 - off, {req, " R4 R6 bit count"}, idx, 64 - off);
    ex = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), ph, r, 2'b10, d};
    bad = 0;
    for (int i = 0; i < idx; i++) begin
      int p;
      bit eo;
      p = off + i;
      eo = w || p < 46;
      if (cap_oe[i] !== eo) bad++;
      else if (eo && cap_o[i] !== ex[63 - p]) bad++;
    end
    chk(bad == 0, {req, " R4 R5 frame bits"}, bad, 0);
    chk(v[15:0] == (w ? d : rv), {req, " R5 data field"}, v[15:0], w ? d : rv);
    rd(1'b0, v);
    chk(v[31], {req, " R9 idle after frame"}, v[31], 1);
  endtask

  task automatic run_frame(input bit w, input bit pre, input logic [4:0] ph, input logic [4:0] r,
                           input logic [15:0] d, input logic [15:0] rv, input string req);
    begin_cap(pre, rv);
    wr(1'b1, uw(w, ph, r, d));
    end_check(w, ph, r, d, rv, req);
  endtask

  function automatic logic [15:0] pat(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hA5C3;
      default: return 16'h8001;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(1'b0, v); chk(v == 32'h8100_00FF, "R1 control reset", v, 32'h8100_00FF);
    rd(1'b1, v); chk(v == 32'h0, "R1 user reset", v, 32'h0);
    chk(!mdio_oe, "R1 oe reset", mdio_oe, 0);

    for (int dv = 1; dv <= 6; dv++) begin
      wr(1'b0, cw(0, 0, 0, 0, 16'(dv)));
      repeat ((dv + 1) * 4 + 4) @(negedge clk);
      chk(last_rise - prev_rise == dv + 1, "R2 mdc period", last_rise - prev_rise, dv + 1);
    end

    wr(1'b0, cw(0, 0, 0, 0, 16'd3));
    begin_cap(0, 16'h1234);
    wr(1'b1, uw(0, 5'd3, 5'd4, 16'h0));
    repeat (120) @(negedge clk);
    rd(1'b1, v);
    chk(idx == 0 && v[31], "R7 no frame while disabled", {v[31], 31'(idx)}, 32'h8000_0000);
    wr(1'b0, cw(1, 0, 0, 0, 16'd3));
    end_check(0, 5'd3, 5'd4, 16'h0, 16'h1234, "R7 after enable");

    for (int pre = 0; pre < 2; pre++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++) begin
          wr(1'b0, cw(1, bit'(pre), 0, 0, 16'd3));
          run_frame(bit'(w), bit'(pre), 5'((k * 9) % 32), 5'(31 - k * 3), pat(k), ~pat(3 - k),
                    pre ? "R6 sweep" : "R4 sweep");
        end

    wr(1'b0, cw(1, 0, 0, 0, 16'd0));
    begin_cap(0, 16'h0);
    wr(1'b1, uw(1, 5'd1, 5'd2, 16'h5A5A));
    repeat (100) @(negedge clk);
    rd(1'b1, v);
    chk(idx == 0 && v[31] && !mdc, "R3 stopped clock", {v[31], mdc, 30'(idx)}, 32'h8000_0000);
    wr(1'b0, cw(1, 0, 0, 0, 16'd3));
    end_check(1, 5'd1, 5'd2, 16'h5A5A, 16'h0, "R3 resume");

    begin_cap(0, 16'h0);
    wr(1'b1, uw(1, 5'd17, 5'd9, 16'hC0DE));
    while (idx < 5) @(negedge clk);
    rd(1'b0, v); chk(!v[31], "R9 busy mid frame", v[31], 0);
    wr(1'b0, cw(0, 0, 0, 0, 16'd3));
    end_check(1, 5'd17, 5'd9, 16'hC0DE, 16'h0, "R8 disable mid frame");
    rd(1'b0, v); chk(!v[30], "R8 enable cleared", v[30], 0);
    begin_cap(0, 16'h0);
    wr(1'b1, uw(1, 5'd2, 5'd2, 16'h1111));
    repeat (150) @(negedge clk);
    rd(1'b1, v);
    chk(idx == 0 && v[31], "R8 no new frame after disable", {v[31], 31'(idx)}, 32'h8000_0000);
    wr(1'b0, cw(1, 0, 0, 0, 16'd3));
    end_check(1, 5'd2, 5'd2, 16'h1111, 16'h0, "R8 flush");

    wr(1'b0, cw(1, 0, 1, 0, 16'd3));
    begin_cap(0, 16'h0);
    wr(1'b1, uw(1, 5'd5, 5'd6, 16'hFFFF));
    while (idx < 3) @(negedge clk);
    inject = 1'b1;
    repeat (12) @(negedge clk);
    inject = 1'b0;
    cap_on = 1'b0;
    rd(1'b0, v); chk(v[19] && v[31], "R10 fault set and idle", {v[31], v[19]}, 2'b11);
    rd(1'b1, v); chk(!v[31], "R10 GO cleared", v[31], 0);
    chk(!mdio_oe, "R10 released", mdio_oe, 0);
    chk(idx < 64, "R10 frame aborted", idx, 64);

    wr(1'b0, cw(1, 0, 1, 0, 16'd3));
    rd(1'b0, v); chk(v[19], "R11 write 0 keeps fault", v[19], 1);
    wr(1'b0, cw(1, 0, 1, 1, 16'd3));
    rd(1'b0, v); chk(!v[19], "R11 write 1 clears fault", v[19], 0);
    run_frame(0, 0, 5'd21, 5'd13, 16'h0, 16'h3C96, "R10 recovery");

    wr(1'b0, cw(1, 0, 0, 0, 16'd3));
    begin_cap(0, 16'h0);
    inject = 1'b1;
    wr(1'b1, uw(1, 5'd30, 5'd1, 16'h6B2D));
    end_check(1, 5'd30, 5'd1, 16'h6B2D, 16'h0, "R12 detect off");
    inject = 1'b0;
    rd(1'b0, v); chk(!v[19], "R12 no fault", v[19], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule